// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers interrupt requests for a small 8-bit processor and decides when one of them is taken. Each vector slot has a request bit and an enable bit. A request bit latches an event strobe and holds it until the request is taken. Software can only clear a request bit. A single global disable flag sits at bit 2 of the processor status word and blocks every maskable slot. A software break is never blocked by that flag.

Several slots have two possible sources. A per-slot selection bit picks which source drives the slot. The two external slots have a further choice: one switch bit selects which of two physical pins feeds them.

The CPU sequencer raises `cpu_ready` at points where an interrupt may be taken. The block then pulses `acc` for one clock and reports the vector index. It also presents the status byte to push onto the stack. In that byte the global flag is shown as it was before the acceptance. The live flag is set to 1 at the same edge. A return command reloads the flag from the status byte popped off the stack. The stack memory, the instruction decoder and the peripherals are outside the block.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the request, enable and source-selection registers and the pin switch read 0, `i_flag` is 1 and `acc` is 0. Register addresses: 0 request, 1 enable, 2 source select (bit i for slot i), 3 pin control (switch at bit 6, other bits read 0).
- R2: An event for slot i sets request bit i. The bit holds while the request is not taken. It clears at the edge where that slot is accepted, and no other request bit changes.
- R3: A write to the request register clears each bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. If an event and a clearing write hit the same bit in one cycle, the bit stays 1.
- R4: With enable bit i at 0, an event still sets request bit i, but slot i is never accepted.
- R5: `sei` sets the global flag and `cli` clears it. While the flag is 1, no maskable slot is accepted.
- R6: While `cpu_ready` is 1 and at least one slot has request, enable and a clear global flag, `acc` pulses one cycle after that edge. `acc_vec` then holds the lowest such slot index and `acc_brk` is 0. While `cpu_ready` is 0, nothing is accepted.
- R7: On acceptance, `push_psw` equals `psw_in` with bit 2 replaced by the global flag from before the acceptance (0 for a maskable slot). `i_flag` is 1 from the same edge on.
- R8: `rti` loads the global flag from bit 2 of `pop_psw`. Priority on the flag is acceptance, then `rti`, then `sei`, then `cli`.
- R9: A `brk` strobe is held pending and is accepted regardless of the global flag. It is reported with `acc_brk`=1 and `acc_vec`=NSLOT (8). It is taken only when no maskable slot is acceptable in the same cycle.
- R10: Source-select bit i set to 0 makes slot i follow its primary source and set to 1 makes it follow `ev_b[i]`. For non-external slots the primary source is `ev_a[i]`.
- R11: Slots 0 and 4 are external. With pin-control bit 6 at 0 their primary sources are `ext_main[0]` and `ext_main[1]`. With the bit at 1 they are `ext_alt[0]` and `ext_alt[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ev_a | input | 8 | Primary event strobes per slot |
| ev_b | input | 8 | Secondary event strobes per slot |
| ext_main | input | 2 | External pin strobes, default pins |
| ext_alt | input | 2 | External pin strobes, alternate pins |
| brk | input | 1 | Software break strobe |
| sei | input | 1 | Set global disable flag |
| cli | input | 1 | Clear global disable flag |
| rti | input | 1 | Return: reload flag from popped status |
| pop_psw | input | 8 | Status byte popped from the stack |
| psw_in | input | 8 | Current status byte from the CPU |
| cpu_ready | input | 1 | Sequencer can take an interrupt this cycle |
| acc | output | 1 | One-cycle acceptance pulse |
| acc_brk | output | 1 | Accepted request is the software break |
| acc_vec | output | 4 | Vector index of the accepted request |
| push_psw | output | 8 | Status byte to push |
| i_flag | output | 1 | Live global disable flag |

## Verification
Single events are run against a closed enable, an open enable with the global flag set, and a closed `cpu_ready`. Each of the three must hold the request latched without acceptance, and they show which gate is checked. Simultaneous events on two slots, and an event together with a break, show the fixed lowest-index order and that a break yields to maskable slots. Each source of a shared slot is pulsed under each selection value, which shows that the unselected source is dropped. Writes of all ones, of a single zero, and of a zero in the same cycle as an event show clear-only software access and the event's precedence over the clear.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NSLOT  = 8,
  parameter int DW     = 8,
  parameter int EXT_A  = 0,
  parameter int EXT_B  = 4,
  parameter int SW_BIT = 6,
  parameter int IBIT   = 2,
  localparam int VW    = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NSLOT-1:0] ev_a,
  input  logic [NSLOT-1:0] ev_b,
  input  logic [1:0]       ext_main,
  input  logic [1:0]       ext_alt,
  input  logic             brk,
  input  logic             sei,
  input  logic             cli,
  input  logic             rti,
  input  logic [7:0]       pop_psw,
  input  logic [7:0]       psw_in,
  input  logic             cpu_ready,
  output logic             acc,
  output logic             acc_brk,
  output logic [VW-1:0]    acc_vec,
  output logic [7:0]       push_psw,
  output logic             i_flag
);

  logic [NSLOT-1:0] req_q, en_q, sel_q, slot_ev, pend, clr_sw, clr_acc;
  logic             sw_q, brk_q, take_m, take_b;
  logic [VW-1:0]    win;
  logic [1:0]       pin_ev;
  logic             unused_bits;

  assign unused_bits = ^{pop_psw, ev_a[EXT_A], ev_a[EXT_B]};

  assign pin_ev = sw_q ? ext_alt : ext_main;

  for (genvar i = 0; i < NSLOT; i++) begin : g_src
    if (i == EXT_A) begin : g_exta
      assign slot_ev[i] = sel_q[i] ? ev_b[i] : pin_ev[0];
    end else if (i == EXT_B) begin : g_extb
      assign slot_ev[i] = sel_q[i] ? ev_b[i] : pin_ev[1];
    end else begin : g_int
      assign slot_ev[i] = sel_q[i] ? ev_b[i] : ev_a[i];
    end
  end

  assign pend = req_q & en_q & {NSLOT{~i_flag}};

  always_comb begin
    win = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (pend[i]) win = VW'(i);
  end

  assign take_m  = cpu_ready & (|pend);
  assign take_b  = cpu_ready & ~(|pend) & brk_q;
  assign clr_sw  = (wr_en && addr == 2'd0) ? ~wdata[NSLOT-1:0] : '0;
  assign clr_acc = take_m ? (NSLOT'(1) << win) : '0;

  always_comb begin
    case (addr)
      2'd0:    rdata = DW'(req_q);
      2'd1:    rdata = DW'(en_q);
      2'd2:    rdata = DW'(sel_q);
      default: rdata = DW'(sw_q) << SW_BIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= '0;
      en_q     <= '0;
      sel_q    <= '0;
      sw_q     <= 1'b0;
      brk_q    <= 1'b0;
      i_flag   <= 1'b1;
      acc      <= 1'b0;
      acc_brk  <= 1'b0;
      acc_vec  <= '0;
      push_psw <= '0;
    end else begin
      req_q <= (req_q & ~clr_sw & ~clr_acc) | slot_ev;
      brk_q <= brk | (brk_q & ~take_b);
      if (wr_en && addr == 2'd1) en_q  <= wdata[NSLOT-1:0];
      if (wr_en && addr == 2'd2) sel_q <= wdata[NSLOT-1:0];
      if (wr_en && addr == 2'd3) sw_q  <= wdata[SW_BIT];
      acc     <= take_m | take_b;
      acc_brk <= take_b;
      if (take_m || take_b) begin
        acc_vec  <= take_m ? win : VW'(NSLOT);
        push_psw <= psw_in;
        push_psw[IBIT] <= i_flag;
        i_flag   <= 1'b1;
      end else if (rti) begin
        i_flag <= pop_psw[IBIT];
      end else if (sei) begin
        i_flag <= 1'b1;
      end else if (cli) begin
        i_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NSLOT = 8,
  parameter int VW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic             acc_brk,
  input logic [VW-1:0]    acc_vec,
  input logic             push_i,
  input logic             i_flag,
  input logic             rti,
  input logic             pop_i,
  input logic             cpu_ready,
  input logic             brk_q,
  input logic [NSLOT-1:0] req_q,
  input logic [NSLOT-1:0] en_q,
  input logic [NSLOT-1:0] slot_ev
);

  p_push_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !acc_brk |-> !push_i);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> i_flag);

  p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !acc_brk |-> ((($past(req_q & en_q)) >> acc_vec) & NSLOT'(1)) != '0);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ev != '0) |=> ((req_q & $past(slot_ev)) == $past(slot_ev)));

  p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(req_q) & ~$past(slot_ev)) == '0));

  p_rti_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rti) && !acc |-> i_flag == $past(pop_i));

  p_brk_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q && cpu_ready && i_flag |=> acc && acc_brk);

  p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> acc_vec <= VW'(NSLOT));

endmodule

bind irq_ctrl irq_ctrl_chk #(.NSLOT(NSLOT), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .acc_brk(acc_brk), .acc_vec(acc_vec),
  .push_i(push_psw[IBIT]), .i_flag(i_flag), .rti(rti), .pop_i(pop_psw[IBIT]),
  .cpu_ready(cpu_ready), .brk_q(brk_q), .req_q(req_q), .en_q(en_q),
  .slot_ev(slot_ev)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] ev_a = 0, ev_b = 0;
  logic [1:0] ext_main = 0, ext_alt = 0;
  logic       brk = 0, sei = 0, cli = 0, rti = 0, cpu_ready = 1;
  logic [7:0] pop_psw = 0, psw_in = 8'hC3, push_psw;
  logic       acc, acc_brk, i_flag;
  logic [3:0] acc_vec;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] expq[$];
  logic [7:0]  r;

  always #5 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_a(ev_a), .ev_b(ev_b), .ext_main(ext_main),
    .ext_alt(ext_alt), .brk(brk), .sei(sei), .cli(cli), .rti(rti),
    .pop_psw(pop_psw), .psw_in(psw_in), .cpu_ready(cpu_ready), .acc(acc),
    .acc_brk(acc_brk), .acc_vec(acc_vec), .push_psw(push_psw), .i_flag(i_flag)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic expect_acc(logic b, logic [3:0] v, logic [7:0] p);
    expq.push_back({b, 3'b0, v, p});
  endtask

  always @(negedge clk) begin
    if (rst_n && acc) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R6 actual=unexpected accept vec %0d expected=none", acc_vec);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        if ({acc_brk, 3'b0, acc_vec, push_psw} !== e) begin
          fails++;
          $display("FAIL R6/R7/R9 actual=%h expected=%h", {acc_brk, 3'b0, acc_vec, push_psw}, e);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_a(logic [7:0] m);
    @(negedge clk); ev_a = m; @(negedge clk); ev_a = 0;
  endtask

  task automatic pulse_b(logic [7:0] m);
    @(negedge clk); ev_b = m; @(negedge clk); ev_b = 0;
  endtask

  task automatic do_sei;
    @(negedge clk); sei = 1; @(negedge clk); sei = 0;
  endtask

  task automatic do_cli;
    @(negedge clk); cli = 1; @(negedge clk); cli = 0;
  endtask

  task automatic do_rti(logic [7:0] p);
    @(negedge clk); rti = 1; pop_psw = p; @(negedge clk); rti = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(0, r); chk("R1 req", r, 8'h00);
    rd(1, r); chk("R1 en", r, 8'h00);
    rd(2, r); chk("R1 sel", r, 8'h00);
    rd(3, r); chk("R1 pin", r, 8'h00);
    chk("R1 iflag", i_flag, 1'b1);
    chk("R1 acc", acc, 1'b0);

    // R4 disabled request latches, not accepted
    do_cli;
    pulse_a(8'h08); idle(3);
    rd(0, r); chk("R4 latched", r, 8'h08);
    // R3 clear-only software writes
    wr(0, 8'hFF); rd(0, r); chk("R3 write ones", r, 8'h08);
    wr(0, 8'hF7); rd(0, r); chk("R3 write zero", r, 8'h00);
    @(negedge clk); ev_a = 8'h08; wr_en = 1; addr = 0; wdata = 8'h00;
    @(negedge clk); ev_a = 0; wr_en = 0;
    rd(0, r); chk("R3 event beats clear", r, 8'h08);
    wr(0, 8'h00);

    // R5 global flag blocks
    do_sei; chk("R5 sei", i_flag, 1'b1);
    wr(1, 8'hFF);
    pulse_a(8'h24); idle(3);
    rd(0, r); chk("R5 blocked", r, 8'h24);
    // R2 / R6 / R7 accept lowest, clear its bit only
    expect_acc(0, 4'd2, 8'hC3);
    do_cli; idle(3);
    chk("R7 flag set", i_flag, 1'b1);
    rd(0, r); chk("R2 accepted bit cleared", r, 8'h20);
    expect_acc(0, 4'd5, 8'hC3);
    do_rti(8'h00); idle(3);
    rd(0, r); chk("R2 second cleared", r, 8'h00);

    // R8 rti loads flag, priority over sei
    do_rti(8'h04); chk("R8 rti one", i_flag, 1'b1);
    do_rti(8'hFB); chk("R8 rti zero", i_flag, 1'b0);
    do_sei;
    @(negedge clk); rti = 1; sei = 1; pop_psw = 8'h00;
    @(negedge clk); rti = 0; sei = 0;
    chk("R8 rti over sei", i_flag, 1'b0);
    do_sei;

    // R9 break ignores flag
    expect_acc(1, 4'd8, 8'hC7);
    @(negedge clk); brk = 1; @(negedge clk); brk = 0;
    idle(3); chk("R9 flag after brk", i_flag, 1'b1);
    // R9 break yields to maskable
    do_cli;
    expect_acc(0, 4'd6, 8'hC3);
    expect_acc(1, 4'd8, 8'hC7);
    @(negedge clk); ev_a = 8'h40; brk = 1;
    @(negedge clk); ev_a = 0; brk = 0;
    idle(4);

    // R6 fixed priority, lowest index
    pulse_a(8'h82); idle(2);
    expect_acc(0, 4'd1, 8'hC3);
    do_cli; idle(3);
    expect_acc(0, 4'd7, 8'hC3);
    do_rti(8'h00); idle(3);

    // R6 cpu_ready gates acceptance
    @(negedge clk); cpu_ready = 0;
    pulse_a(8'h08); do_cli; idle(4);
    rd(0, r); chk("R6 not ready holds", r, 8'h08);
    expect_acc(0, 4'd3, 8'hC3);
    @(negedge clk); cpu_ready = 1; idle(3);
    rd(0, r); chk("R6 ready accepts", r, 8'h00);

    // R10 source selection (enables off to observe latches)
    wr(1, 8'h00);
    wr(2, 8'h02);
    pulse_a(8'h02); rd(0, r); chk("R10 sel1 drops primary", r, 8'h00);
    pulse_b(8'h02); rd(0, r); chk("R10 sel1 takes secondary", r, 8'h02);
    wr(0, 8'h00); wr(2, 8'h00);
    pulse_b(8'h02); rd(0, r); chk("R10 sel0 drops secondary", r, 8'h00);
    pulse_a(8'h02); rd(0, r); chk("R10 sel0 takes primary", r, 8'h02);
    wr(0, 8'h00);

    // R11 pin switch
    @(negedge clk); ext_alt = 2'b11; @(negedge clk); ext_alt = 0;
    rd(0, r); chk("R11 sw0 drops alt", r, 8'h00);
    @(negedge clk); ext_main = 2'b11; @(negedge clk); ext_main = 0;
    rd(0, r); chk("R11 sw0 takes main", r, 8'h11);
    wr(0, 8'h00); wr(3, 8'h40);
    rd(3, r); chk("R11 pin reg", r, 8'h40);
    @(negedge clk); ext_main = 2'b11; @(negedge clk); ext_main = 0;
    rd(0, r); chk("R11 sw1 drops main", r, 8'h00);
    @(negedge clk); ext_alt = 2'b11; @(negedge clk); ext_alt = 0;
    rd(0, r); chk("R11 sw1 takes alt", r, 8'h11);
    wr(0, 8'h00); wr(2, 8'h01);
    @(negedge clk); ext_alt = 2'b11; @(negedge clk); ext_alt = 0;
    rd(0, r); chk("R10 ext slot selected away", r, 8'h10);
    pulse_b(8'h01); rd(0, r); chk("R10 ext slot secondary", r, 8'h11);

    idle(5);
    chk("R6 all expected accepts seen", expq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule